// File: doc/BRIEF.md
# Zero-Turnaround Pipelined SRAM Core

This block models a synchronous, fully pipelined static memory that accepts a new read or write on every clock without idle cycles when the bus direction changes. All commands are taken on the rising edge. A load command carries the address, three chip-select terms, the read/write choice and a per-lane write mask. A continue command makes the block generate the next address of a four-beat burst from an internal two-bit counter. Burst order is interleaved or linear, chosen by a static select input. Write data follows its address by two active edges, which lets a read and a write sit in the pipeline together. Read data arrives on a registered output two active edges after its address cycle.

A read that follows a write to the same word may fetch the array before that write has landed. A one-entry bypass then merges the freshly written lanes into the returned word, so the data stays coherent. A clock-enable input freezes the whole pipeline. A snooze input puts the block to rest and keeps the array contents. An asynchronous output enable gates only the visible read data. The memory depth is a parameter and is kept small for simulation.

Top module: `zt_sram_core`

## Requirements
- R1: A read loaded at active edge k puts the stored word on `rdata` after edge k+2, with `rdata_vld` high. `rdata_vld` is low after edge k+1 when the command before it was not a read.
- R2: With `ld_n` low, the cycle is a deselect unless `en0_n`=0, `en1`=1 and `en2_n`=0 all hold. A deselect writes nothing and raises no valid. Continue cycles after a deselect stay deselects.
- R3: With `ld_n` high, `rd_wr_n` and `addr` are ignored, and a burst keeps the read or write type of its load cycle.
- R4: A write loaded at edge k stores `wdata` lane i, bits [i*9+8:i*9], at edge k+2 only where `lane_we_n[i]`=0; the mask is sampled on each command cycle. With all mask bits high, the write is an abort and leaves the word unchanged.
- R5: For a burst from start address s, beat n (n counts from 0 and wraps after 4) uses low two bits (s[1:0] XOR n) when `order_ilv`=1 and (s[1:0]+n) mod 4 when `order_ilv`=0. Bits above bit 1 stay equal to s.
- R6: While `cke_n`=1, a clock edge changes no state: pending commands, `rdata` and `rdata_vld` all hold.
- R7: While `zz`=1, and for the 2 edges after it falls, commands and `cke_n` are ignored and `rdata_vld` is low. A write already loaded still completes, and the array keeps its contents.
- R8: `oe_n`=1 forces `rdata` to zero at once without touching the pipeline or `rdata_vld`.
- R9: A read loaded one cycle after a write to the same address returns the new lanes of that write merged with the old lanes.
- R10: Reads and writes may alternate on consecutive cycles, and each returns or stores the right word.
- R11: `rdata_vld` rises only for read cycles. It stays low for write, abort and deselect slots.
- R12: After reset, `rdata_vld` is 0, `rdata` is 0 and the pipeline holds deselects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline |
| cke_n | input | 1 | Active-low clock enable; high freezes all state |
| zz | input | 1 | Snooze request, active high |
| ld_n | input | 1 | Low loads a new command, high continues the burst |
| en0_n | input | 1 | Active-low chip select term |
| en1 | input | 1 | Active-high chip select term |
| en2_n | input | 1 | Active-low chip select term |
| rd_wr_n | input | 1 | High read, low write; used on load cycles only |
| lane_we_n | input | LANES | Active-low write mask, one bit per lane |
| addr | input | ADDR_W | Word address, used on load cycles |
| order_ilv | input | 1 | Static burst order select: 1 interleaved, 0 linear |
| wdata | input | LANES*LANE_W | Write data, taken two active edges after its command |
| oe_n | input | 1 | Asynchronous active-low output enable |
| rdata | output | LANES*LANE_W | Registered read data, zero while oe_n is high |
| rdata_vld | output | 1 | High when rdata holds a read result |

## Verification
The hardest case to reach is the coherency window. A read must fetch the array on the same edge that an older write commits, and only a write one cycle ahead of a same-address read lands there. The bench issues a partial-mask write, follows it at once with a read of that word, and supplies the write data two cycles later. It then compares the result against the merge of old and new lanes. Snooze is driven with a write already in flight, and reads are tried during the recovery edges.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
   // operation class carried down the pipeline
   typedef enum logic [1:0] {
      OP_DSEL = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } zt_op_e;
endpackage

// File: rtl/zt_burst_addr.sv
module zt_burst_addr #(
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = 0   // 0: pin selected, 1: linear only, 2: interleaved only
) (
   input  logic [BURST_W-1:0] start_lo,
   input  logic [BURST_W-1:0] beat,
   input  logic               ilv_sel,
   output logic [BURST_W-1:0] addr_lo
);
   generate
      if (ORDER_MODE == 1) begin : g_lin
         logic unused_sel;
         assign unused_sel = ilv_sel;
         assign addr_lo    = start_lo + beat;
      end else if (ORDER_MODE == 2) begin : g_ilv
         logic unused_sel;
         assign unused_sel = ilv_sel;
         assign addr_lo    = start_lo ^ beat;
      end else begin : g_sel
         assign addr_lo = ilv_sel ? (start_lo ^ beat) : (start_lo + beat);
      end
   endgenerate
endmodule

// File: rtl/zt_cmd_ctrl.sv
module zt_cmd_ctrl
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 8,
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              blocked,
   input  logic              ld_n,
   input  logic              sel,
   input  logic              rd_wr_n,
   input  logic [LANES-1:0]  lane_we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ilv_sel,
   output zt_op_e            s1_op,
   output logic [ADDR_W-1:0] s1_addr,
   output logic [LANES-1:0]  s1_we_n
);
   localparam int HI_W = ADDR_W - BURST_W;

   zt_op_e             cur_op;
   logic [HI_W-1:0]    base_hi;
   logic [BURST_W-1:0] start_lo;
   logic [BURST_W-1:0] beat_cnt;
   logic [BURST_W-1:0] nxt_cnt;
   logic [BURST_W-1:0] nxt_lo;
   zt_op_e             load_op;

   assign nxt_cnt = beat_cnt + BURST_W'(1);
   assign load_op = !sel ? OP_DSEL : (rd_wr_n ? OP_RD : OP_WR);

   zt_burst_addr #(.BURST_W(BURST_W), .ORDER_MODE(ORDER_MODE)) u_burst (
      .start_lo (start_lo),
      .beat     (nxt_cnt),
      .ilv_sel  (ilv_sel),
      .addr_lo  (nxt_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_op   <= OP_DSEL;
         base_hi  <= '0;
         start_lo <= '0;
         beat_cnt <= '0;
         s1_op    <= OP_DSEL;
         s1_addr  <= '0;
         s1_we_n  <= '1;
      end else if (step) begin
         if (blocked) begin
            cur_op <= OP_DSEL;
            s1_op  <= OP_DSEL;
         end else if (!ld_n) begin
            cur_op   <= load_op;
            base_hi  <= addr[ADDR_W-1:BURST_W];
            start_lo <= addr[BURST_W-1:0];
            beat_cnt <= '0;
            s1_op    <= load_op;
            s1_addr  <= addr;
            s1_we_n  <= lane_we_n;
         end else begin
            beat_cnt <= nxt_cnt;
            s1_op    <= cur_op;
            s1_addr  <= {base_hi, nxt_lo};
            s1_we_n  <= lane_we_n;
         end
      end
   end

   AST_DSEL_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blocked && !ld_n && !sel) |=> (s1_op == OP_DSEL));   // R2
   AST_BURST_KEEPS_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blocked && ld_n) |=> (s1_op == $past(s1_op)));   // R3
   AST_HIGH_BITS_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !blocked && ld_n) |=> (s1_addr[ADDR_W-1:BURST_W] == $past(s1_addr[ADDR_W-1:BURST_W])));   // R5
   AST_STALL_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> ($stable(s1_op) && $stable(s1_addr) && $stable(s1_we_n)));   // R6
endmodule

// File: rtl/zt_lane_store.sv
module zt_lane_store #(
   parameter int ADDR_W = 6,
   parameter int LANE_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [LANE_W-1:0] wr_data,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [ADDR_W-1:0] cmp_addr,
   output logic [LANE_W-1:0] lane_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [LANE_W-1:0] arr [DEPTH];
   logic [LANE_W-1:0] raw_q;
   logic              wc_vld;
   logic [ADDR_W-1:0] wc_addr;
   logic [LANE_W-1:0] wc_data;

   // array: commit and fetch on the same active edge
   always_ff @(posedge clk) begin
      if (step) begin
         if (wr_en) arr[wr_addr] <= wr_data;
         if (rd_en) raw_q <= arr[rd_addr];
      end
   end

   // last committed lane write, used when the fetch raced it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wc_vld  <= 1'b0;
         wc_addr <= '0;
         wc_data <= '0;
      end else if (step) begin
         wc_vld  <= wr_en;
         wc_addr <= wr_addr;
         wc_data <= wr_data;
      end
   end

   assign lane_q = (wc_vld && (wc_addr == cmp_addr)) ? wc_data : raw_q;

   AST_BYPASS_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (step && wr_en) |=> (wc_vld && (wc_data == $past(wr_data))));   // R9
endmodule

// File: rtl/zt_sram_core.sv
module zt_sram_core
   import zt_sram_pkg::*;
#(
   parameter int ADDR_W     = 6,
   parameter int LANES      = 8,
   parameter int LANE_W     = 9,
   parameter int BURST_W    = 2,
   parameter int ORDER_MODE = 0,
   parameter int SNOOZE_CYC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     cke_n,
   input  logic                     zz,
   input  logic                     ld_n,
   input  logic                     en0_n,
   input  logic                     en1,
   input  logic                     en2_n,
   input  logic                     rd_wr_n,
   input  logic [LANES-1:0]         lane_we_n,
   input  logic [ADDR_W-1:0]        addr,
   input  logic                     order_ilv,
   input  logic [LANES*LANE_W-1:0]  wdata,
   input  logic                     oe_n,
   output logic [LANES*LANE_W-1:0]  rdata,
   output logic                     rdata_vld
);
   localparam int DW = LANES * LANE_W;

   generate
      if (ADDR_W <= BURST_W) begin : g_chk_addr
         $error("ADDR_W must exceed BURST_W");
      end
      if (BURST_W < 1) begin : g_chk_burst
         $error("BURST_W must be at least 1");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_chk_lane
         $error("LANES and LANE_W must be positive");
      end
      if (SNOOZE_CYC < 1) begin : g_chk_zz
         $error("SNOOZE_CYC must be at least 1");
      end
      if (ORDER_MODE < 0 || ORDER_MODE > 2) begin : g_chk_order
         $error("ORDER_MODE must be 0, 1 or 2");
      end
   endgenerate

   logic                  blocked;
   logic                  step;
   logic                  sel;
   logic [SNOOZE_CYC-1:0] zz_hist;

   zt_op_e                s1_op;
   logic [ADDR_W-1:0]     s1_addr;
   logic [LANES-1:0]      s1_we_n;
   zt_op_e                s2_op;
   logic [ADDR_W-1:0]     s2_addr;
   logic [LANES-1:0]      s2_we_n;
   logic                  wr_commit;

   logic [LANES-1:0][LANE_W-1:0] lane_rd;
   logic [DW-1:0]                q_r;
   logic                         vld_r;

   assign blocked   = zz | (|zz_hist);
   assign step      = !cke_n | blocked;
   assign sel       = !en0_n & en1 & !en2_n;
   assign wr_commit = step & (s2_op == OP_WR);

   zt_cmd_ctrl #(
      .ADDR_W(ADDR_W), .LANES(LANES), .BURST_W(BURST_W), .ORDER_MODE(ORDER_MODE)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .step      (step),
      .blocked   (blocked),
      .ld_n      (ld_n),
      .sel       (sel),
      .rd_wr_n   (rd_wr_n),
      .lane_we_n (lane_we_n),
      .addr      (addr),
      .ilv_sel   (order_ilv),
      .s1_op     (s1_op),
      .s1_addr   (s1_addr),
      .s1_we_n   (s1_we_n)
   );

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         zt_lane_store #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (step),
            .wr_en    (wr_commit & !s2_we_n[i]),
            .wr_addr  (s2_addr),
            .wr_data  (wdata[i*LANE_W +: LANE_W]),
            .rd_en    (s1_op == OP_RD),
            .rd_addr  (s1_addr),
            .cmp_addr (s2_addr),
            .lane_q   (lane_rd[i])
         );
      end
   endgenerate

   // snooze history runs on every edge, independent of the clock enable
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) zz_hist <= '0;
      else        zz_hist <= (zz_hist << 1) | SNOOZE_CYC'(zz);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s2_op   <= OP_DSEL;
         s2_addr <= '0;
         s2_we_n <= '1;
         q_r     <= '0;
         vld_r   <= 1'b0;
      end else if (step) begin
         s2_op   <= s1_op;
         s2_addr <= s1_addr;
         s2_we_n <= s1_we_n;
         if (blocked) begin
            vld_r <= 1'b0;
         end else begin
            vld_r <= (s2_op == OP_RD);
            if (s2_op == OP_RD) q_r <= lane_rd;
         end
      end
   end

   assign rdata     = oe_n ? '0 : q_r;
   assign rdata_vld = vld_r;

   AST_VLD_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdata_vld) |-> ($past(s2_op) == OP_RD));   // R11
   AST_SNOOZE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      zz |=> !rdata_vld);   // R7
   AST_STALL_HOLDS_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      (cke_n && !blocked) |=> ($stable(rdata_vld) && $stable(q_r) && $stable(s2_op)));   // R6
endmodule

// File: tb/zt_sram_core_tb.sv
`timescale 1ns/1ps
module zt_sram_core_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cke_n = 1'b0;
   logic        zz = 1'b0;
   logic        ld_n = 1'b0;
   logic        en0_n = 1'b1;
   logic        en1 = 1'b1;
   logic        en2_n = 1'b0;
   logic        rd_wr_n = 1'b1;
   logic [7:0]  lane_we_n = '1;
   logic [5:0]  addr = '0;
   logic        order_ilv = 1'b1;
   logic [71:0] wdata = '0;
   logic        oe_n = 1'b0;
   logic [71:0] rdata;
   logic        rdata_vld;

   int total = 0;
   int bad = 0;
   logic [71:0] ref_mem [64];

   always #5 clk = ~clk;

   zt_sram_core u_dut (
      .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .zz(zz), .ld_n(ld_n),
      .en0_n(en0_n), .en1(en1), .en2_n(en2_n), .rd_wr_n(rd_wr_n),
      .lane_we_n(lane_we_n), .addr(addr), .order_ilv(order_ilv),
      .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .rdata_vld(rdata_vld)
   );

   function automatic logic [71:0] mk(input int a, input int salt);
      logic [71:0] r;
      for (int i = 0; i < 8; i++) r[i*9 +: 9] = 9'((a * 13 + i * 37 + salt * 5 + 1) & 511);
      return r;
   endfunction

   function automatic logic [71:0] mrg(input logic [71:0] old, input logic [71:0] nw,
                                        input logic [7:0] bwn);
      logic [71:0] r;
      for (int i = 0; i < 8; i++) r[i*9 +: 9] = bwn[i] ? old[i*9 +: 9] : nw[i*9 +: 9];
      return r;
   endfunction

   function automatic int beat_addr(input int s, input bit ilv, input int n);
      int lo;
      lo = ilv ? ((s & 3) ^ (n & 3)) : (((s & 3) + n) & 3);
      return (s & ~3) | lo;
   endfunction

   task automatic chk(input string tag, input logic [71:0] act, input logic [71:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one command cycle: drive after a falling edge, return after the next falling edge
   task automatic cyc(input bit ld, input int csb, input bit rd, input logic [7:0] bwn,
                      input int a, input logic [71:0] wd);
      ld_n      = !ld;
      en0_n     = (csb == 1);
      en1       = (csb != 2);
      en2_n     = (csb == 3);
      rd_wr_n   = rd;
      lane_we_n = bwn;
      addr      = 6'(a);
      wdata     = wd;
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic nop(input logic [71:0] wd);
      cyc(1, 1, 1, 8'hFF, 0, wd);
   endtask

   task automatic wrm(input int a, input logic [7:0] bwn, input logic [71:0] d);
      cyc(1, 0, 0, bwn, a, '0);
      nop('0);
      nop(d);
      ref_mem[a] = mrg(ref_mem[a], d, bwn);
   endtask

   task automatic rd1(input int a, input string tag);
      cyc(1, 0, 1, 8'hFF, a, '0);
      nop('0);
      nop('0);
      chk(tag, rdata, ref_mem[a]);
      chk(tag, 72'(rdata_vld), 72'd1);
   endtask

   task automatic t_reset;
      chk("R12 reset vld", 72'(rdata_vld), 72'd0);
      chk("R12 reset data", rdata, '0);
   endtask

   task automatic t_basic;
      wrm(5, 8'h00, mk(5, 1));
      chk("R11 no vld after write", 72'(rdata_vld), 72'd0);
      cyc(1, 0, 1, 8'hFF, 5, '0);
      chk("R1 vld low at edge k", 72'(rdata_vld), 72'd0);
      nop('0);
      chk("R1 vld low at edge k+1", 72'(rdata_vld), 72'd0);
      nop('0);
      chk("R1 data at edge k+2", rdata, ref_mem[5]);
      chk("R1 vld at edge k+2", 72'(rdata_vld), 72'd1);
   endtask

   task automatic t_mask;
      wrm(5, 8'hFE, '1);
      rd1(5, "R4 lane0 only");
      cyc(1, 0, 0, 8'hFF, 5, '0);
      nop('0);
      nop(mk(50, 9));
      chk("R11 abort no vld", 72'(rdata_vld), 72'd0);
      rd1(5, "R4 abort keeps word");
   endtask

   task automatic t_coherent;
      logic [71:0] nw;
      wrm(9, 8'h00, mk(9, 2));
      nw = mk(9, 7);
      cyc(1, 0, 0, 8'hF7, 9, '0);
      cyc(1, 0, 1, 8'hFF, 9, '0);
      ref_mem[9] = mrg(ref_mem[9], nw, 8'hF7);
      nop(nw);
      nop('0);
      chk("R9 merged read", rdata, ref_mem[9]);
      chk("R9 merged vld", 72'(rdata_vld), 72'd1);
      // alternating read / write / read
      cyc(1, 0, 1, 8'hFF, 5, '0);
      cyc(1, 0, 0, 8'h00, 7, '0);
      cyc(1, 0, 1, 8'hFF, 7, '0);
      chk("R10 first read", rdata, ref_mem[5]);
      ref_mem[7] = mk(7, 4);
      nop(ref_mem[7]);
      chk("R11 write slot no vld", 72'(rdata_vld), 72'd0);
      nop('0);
      chk("R10 read after write", rdata, ref_mem[7]);
      chk("R10 vld", 72'(rdata_vld), 72'd1);
   endtask

   task automatic burst_rd(input int s, input bit ilv, input string tag);
      order_ilv = ilv;
      for (int i = 0; i < 7; i++) begin
         if (i == 0) cyc(1, 0, 1, 8'hFF, s, '0);
         else if (i < 5) cyc(0, 0, 0, 8'hFF, (s + 17 * i) & 63, '0);
         else nop('0);
         if (i >= 2) begin
            chk(tag, rdata, ref_mem[beat_addr(s, ilv, i - 2)]);
            chk(tag, 72'(rdata_vld), 72'd1);
         end
      end
      nop('0);
      chk("R11 vld drops after burst", 72'(rdata_vld), 72'd0);
   endtask

   task automatic burst_wr(input int s, input bit ilv);
      order_ilv = ilv;
      for (int i = 0; i < 6; i++) begin
         logic [71:0] wd;
         wd = '0;
         if (i >= 2) begin
            wd = mk(beat_addr(s, ilv, i - 2), 11);
            ref_mem[beat_addr(s, ilv, i - 2)] = wd;
         end
         if (i == 0) cyc(1, 0, 0, 8'h00, s, wd);
         else if (i < 4) cyc(0, 0, 1, 8'h00, 63, wd);
         else nop(wd);
      end
   endtask

   task automatic t_burst;
      for (int a = 16; a < 24; a++) wrm(a, 8'h00, mk(a, 3));
      burst_rd(18, 1'b1, "R5 interleaved R3 type kept");
      burst_rd(19, 1'b0, "R5 linear wrap");
      burst_wr(26, 1'b0);
      for (int n = 0; n < 4; n++) rd1(24 + n, "R3 burst write kept type");
   endtask

   task automatic t_desel;
      for (int b = 1; b < 4; b++) begin
         cyc(1, b, 0, 8'h00, 5, '0);
         cyc(0, 0, 1, 8'h00, 5, '0);
         cyc(0, 0, 1, 8'h00, 5, mk(99, b));
         chk("R2 deselect no vld", 72'(rdata_vld), 72'd0);
         nop(mk(98, b));
         chk("R2 deselect continue no vld", 72'(rdata_vld), 72'd0);
      end
      rd1(5, "R2 deselect wrote nothing");
   endtask

   task automatic t_stall;
      cyc(1, 0, 1, 8'hFF, 16, '0);
      cyc(1, 0, 1, 8'hFF, 17, '0);
      nop('0);
      chk("R6 before stall", rdata, ref_mem[16]);
      cke_n = 1'b1;
      cyc(1, 0, 1, 8'hFF, 20, '0);
      chk("R6 stall data held", rdata, ref_mem[16]);
      cyc(1, 0, 0, 8'h00, 21, '0);
      chk("R6 stall vld held", 72'(rdata_vld), 72'd1);
      cke_n = 1'b0;
      nop('0);
      chk("R6 resume second read", rdata, ref_mem[17]);
      nop('0);
      chk("R6 nothing from stalled cmds", 72'(rdata_vld), 72'd0);
      cyc(1, 0, 0, 8'h00, 40, '0);
      cke_n = 1'b1;
      nop(mk(1, 1));
      nop(mk(2, 2));
      cke_n = 1'b0;
      nop(mk(3, 3));
      ref_mem[40] = mk(40, 6);
      nop(ref_mem[40]);
      rd1(40, "R6 write data at second active edge");
   endtask

   task automatic t_oe;
      rd1(16, "R8 baseline");
      oe_n = 1'b1;
      #1;
      chk("R8 oe high zero data", rdata, '0);
      chk("R8 oe high vld kept", 72'(rdata_vld), 72'd1);
      oe_n = 1'b0;
      #1;
      chk("R8 oe low data back", rdata, ref_mem[16]);
      oe_n = 1'b1;
      cyc(1, 0, 1, 8'hFF, 17, '0);
      nop('0);
      nop('0);
      oe_n = 1'b0;
      #1;
      chk("R8 pipeline unaffected", rdata, ref_mem[17]);
   endtask

   task automatic t_snooze;
      cyc(1, 0, 0, 8'h00, 30, '0);
      zz = 1'b1;
      cyc(1, 0, 1, 8'hFF, 16, '0);
      ref_mem[30] = mk(30, 8);
      cyc(1, 0, 0, 8'h00, 5, ref_mem[30]);
      chk("R7 no vld entering", 72'(rdata_vld), 72'd0);
      for (int i = 0; i < 3; i++) begin
         cyc(1, 0, 0, 8'h00, 5, mk(77, i));
         chk("R7 no vld asleep", 72'(rdata_vld), 72'd0);
      end
      zz = 1'b0;
      cyc(1, 0, 1, 8'hFF, 16, '0);
      chk("R7 recovery edge 1", 72'(rdata_vld), 72'd0);
      cyc(1, 0, 1, 8'hFF, 16, '0);
      chk("R7 recovery edge 2", 72'(rdata_vld), 72'd0);
      nop('0);
      chk("R7 recovery cmds ignored a", 72'(rdata_vld), 72'd0);
      nop('0);
      chk("R7 recovery cmds ignored b", 72'(rdata_vld), 72'd0);
      rd1(30, "R7 in-flight write done");
      rd1(5, "R7 array kept");
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mask();
      t_coherent();
      t_burst();
      t_desel();
      t_stall();
      t_oe();
      t_snooze();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(10 * 150000);
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule